// File: doc/BRIEF.md
# Interlocked Two-Phase PWM Generator

This block drives the two gate-control phases of a full bridge from a single shared timebase. A host loads four 8-bit registers: the pulse-width setting for phase A, the pulse-width setting for phase B, a clock divisor, and a spare register. The divisor feeds a modulo-n prescaler. The prescaler's tick advances a half-period counter. Each switching period has two equal halves. Phase A may only be high at the start of the first half, and phase B only at the start of the second half. The two phases therefore can never overlap.

Each pulse width scales linearly with its register. Full scale is capped at 95% of a half-period, which always leaves a dead band before the other phase turns on. The duty and divisor values are captured into shadow copies only when a full period starts, so a write never truncates or stretches a pulse already in flight. The generator keeps running on the last captured values for as long as the host stays silent.

A small sequencer steps through three named states. `ST_LOAD` is entered on reset, captures the shadows, and always moves to `ST_FIRST`. `ST_FIRST` covers the phase-A half and moves to `ST_SECOND` on the last tick of the half. `ST_SECOND` covers the phase-B half and returns to `ST_FIRST` on its last tick, recapturing the shadows as it does so.

Top module: `biphase_pwm`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four registers to 0 and clears the prescaler and half-period counter. Both `pwm_a` and `pwm_b` stay low during reset and for the clock that follows it.
- R2: Register addresses are: 0 = phase A setting, 1 = phase B setting, 2 = divisor, 3 = spare. `rd_data` returns the register selected by `rd_addr` combinationally. Writing the spare register has no effect on either output.
- R3: One switching period lasts 2·HALF_TICKS·D clocks, where D is the effective divisor. At the defaults (HALF_TICKS = 250, D = 1), a 50 MHz clock gives a 500-clock period, which is 100 kHz.
- R4: Per period, `pwm_a` is high for floor(SA·CAP/255)·D consecutive clocks. SA is the phase A setting, and CAP = floor(HALF_TICKS·19/20). `pwm_b` follows the same rule using the phase B setting.
- R5: `pwm_a` rises at the first clock of a period. `pwm_b` rises exactly HALF_TICKS·D clocks after `pwm_a` would rise.
- R6: `pwm_a` and `pwm_b` are never high in the same clock. Each pulse ends no later than tick CAP of its half.
- R7: A divisor value of 0 behaves exactly like a divisor of 1.
- R8: New duty and divisor values take effect only at the start of the next full period. A pulse in progress keeps its captured width.
- R9: With no further writes, every period repeats the same pulse widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| pwm_a | output | 1 | Phase A drive, first half-period |
| pwm_b | output | 1 | Phase B drive, second half-period |

## Verification
The bench builds the block with HALF_TICKS = 20 and leaves the data width at 8. That makes CAP 19 and a period at divisor 1 only 40 clocks long. Full-scale pulses, the one-tick dead band, rounding to zero width, and divisors up to 4 (including 0) can all be measured over whole periods in a few hundred clocks. The short period also lets the bench write a register in the middle of a pulse and see the capture happen at the next period start.

// File: rtl/biphase_pwm_pkg.sv
package biphase_pwm_pkg;
    typedef enum logic [1:0] {
        ST_LOAD   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } seq_state_t;

    localparam int NUM_REGS = 4;
    localparam int ADDR_DUTY_A = 0;
    localparam int ADDR_DUTY_B = 1;
    localparam int ADDR_DIV    = 2;
endpackage

// File: rtl/biphase_pwm_regs.sv
module biphase_pwm_regs #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] duty_a,
    output logic [DATA_W-1:0] duty_b,
    output logic [DATA_W-1:0] div_val
);
    import biphase_pwm_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                bank[i] <= '0;
            end
        end else if (wr_en) begin
            bank[wr_addr] <= wr_data;
        end
    end

    assign rd_data = bank[rd_addr];
    assign duty_a  = bank[ADDR_DUTY_A];
    assign duty_b  = bank[ADDR_DUTY_B];
    assign div_val = bank[ADDR_DIV];

    // R1: one cycle after reset the bank reads zero at every address
    p_bank_clear_r1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (rd_data == '0));
endmodule

// File: rtl/biphase_pwm_prescaler.sv
module biphase_pwm_prescaler #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic [DATA_W-1:0] div_i,
    output logic              tick
);
    logic [DATA_W-1:0] pre;
    logic [DATA_W-1:0] div_eff;

    assign div_eff = (div_i == '0) ? DATA_W'(1) : div_i;
    assign tick    = (pre == div_eff - DATA_W'(1));

    always_ff @(posedge clk) begin
        if (rst || clr || tick) begin
            pre <= '0;
        end else begin
            pre <= pre + DATA_W'(1);
        end
    end

    // R7: the prescaler never passes the effective divisor, so zero acts as one
    p_pre_bound_r7: assert property (@(posedge clk) disable iff (rst)
        pre < div_eff);
endmodule

// File: rtl/biphase_pwm_seq.sv
module biphase_pwm_seq #(
    parameter int DATA_W     = 8,
    parameter int HALF_TICKS = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [DATA_W-1:0] duty_a_i,
    input  logic [DATA_W-1:0] duty_b_i,
    input  logic [DATA_W-1:0] div_i,
    output logic [DATA_W-1:0] sh_div,
    output logic              load,
    output logic              pwm_a,
    output logic              pwm_b
);
    import biphase_pwm_pkg::*;

    localparam int CAP    = (HALF_TICKS * 19) / 20;
    localparam int CNT_W  = $clog2(HALF_TICKS + 1);
    localparam int FULL   = (1 << DATA_W) - 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_TICKS - 1);

    function automatic logic [CNT_W-1:0] scale_on(input logic [DATA_W-1:0] d);
        int prod;
        prod = (int'(d) * CAP) / FULL;
        return CNT_W'(prod);
    endfunction

    seq_state_t state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  on_a, on_b;
    logic              half_end;

    assign half_end = tick && (cnt == LAST);
    assign load     = (state == ST_LOAD) || (half_end && state == ST_SECOND);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:   state_nx = ST_FIRST;
            ST_FIRST:  if (half_end) state_nx = ST_SECOND;
            ST_SECOND: if (half_end) state_nx = ST_FIRST;
            default:   state_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_LOAD;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || state == ST_LOAD) begin
            cnt <= '0;
        end else if (half_end) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            on_a   <= '0;
            on_b   <= '0;
            sh_div <= '0;
        end else if (load) begin
            on_a   <= scale_on(duty_a_i);
            on_b   <= scale_on(duty_b_i);
            sh_div <= div_i;
        end
    end

    always_comb begin
        pwm_a = 1'b0;
        pwm_b = 1'b0;
        unique case (state)
            ST_LOAD:   ;
            ST_FIRST:  pwm_a = (cnt < on_a);
            ST_SECOND: pwm_b = (cnt < on_b);
            default:   ;
        endcase
    end

    // R8: captured settings change only on a load
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(on_a) && $stable(on_b) && $stable(sh_div)));

    // R6: each pulse stays inside the capped part of its half
    p_dead_band_r6: assert property (@(posedge clk) disable iff (rst)
        (pwm_a || pwm_b) |-> (cnt < CNT_W'(CAP)));

    // R5: phase A starts only at the first tick of the first half
    p_a_start_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(pwm_a) |-> (state == ST_FIRST && cnt == '0));

    // R1: the clock after reset leaves both phases low
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!pwm_a && !pwm_b));
endmodule

// File: rtl/biphase_pwm.sv
module biphase_pwm #(
    parameter int DATA_W     = 8,
    parameter int HALF_TICKS = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_a,
    output logic              pwm_b
);
    logic [DATA_W-1:0] duty_a, duty_b, div_val, sh_div;
    logic              tick, load;

    biphase_pwm_regs #(.DATA_W(DATA_W), .ADDR_W(2)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .duty_a  (duty_a),
        .duty_b  (duty_b),
        .div_val (div_val)
    );

    biphase_pwm_prescaler #(.DATA_W(DATA_W)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (load),
        .div_i (sh_div),
        .tick  (tick)
    );

    biphase_pwm_seq #(.DATA_W(DATA_W), .HALF_TICKS(HALF_TICKS)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .duty_a_i (duty_a),
        .duty_b_i (duty_b),
        .div_i    (div_val),
        .sh_div   (sh_div),
        .load     (load),
        .pwm_a    (pwm_a),
        .pwm_b    (pwm_b)
    );

    // R6: the two phases are never high together
    p_no_overlap_r6: assert property (@(posedge clk) disable iff (rst)
        !(pwm_a && pwm_b));
endmodule

// File: tb/biphase_pwm_test.sv
module biphase_pwm_test;
    localparam int HALF = 20;
    localparam int CAP  = (HALF * 19) / 20;
    localparam int NV   = 6;
    // each row: setting A, setting B, divisor
    localparam int VEC [NV][3] = '{
        '{255, 255, 1},
        '{  0, 128, 1},
        '{128,   0, 2},
        '{ 64, 200, 3},
        '{255,  10, 0},
        '{  1, 254, 4}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pwm_a, pwm_b;

    int    checks = 0;
    int    fails  = 0;
    longint cyc   = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    biphase_pwm #(.DATA_W(8), .HALF_TICKS(HALF)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic int exp_on(input int d);
        return (d * CAP) / 255;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_addr = 2'(a);
        #1 v = int'(rd_data);
    endtask

    task automatic measure(input int n, output int h1, output int h2, output int ov);
        h1 = 0; h2 = 0; ov = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            h1 += int'(pwm_a);
            h2 += int'(pwm_b);
            ov += int'(pwm_a && pwm_b);
        end
    endtask

    task automatic wait_rise(input bit sel_b, output longint t, output bit ok);
        bit prev, cur;
        ok = 1'b0; t = 0;
        @(negedge clk);
        prev = sel_b ? pwm_b : pwm_a;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            cur = sel_b ? pwm_b : pwm_a;
            if (cur && !prev) begin
                t = cyc; ok = 1'b1;
                return;
            end
            prev = cur;
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R3 watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int h1, h2, ov, g1, g2, gv, v, deff, per, cnt_hi;
        longint t0, t1, t2;
        bit ok;

        // R1: state during and right after reset
        repeat (3) @(negedge clk);
        chk("R1", "pwm_a in reset", pwm_a, 0);
        chk("R1", "pwm_b in reset", pwm_b, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "pwm_a after reset", pwm_a, 0);
        chk("R1", "pwm_b after reset", pwm_b, 0);
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            chk("R1", $sformatf("reg %0d after reset", a), v, 0);
        end

        // table walk: R3 R4 R5 R6 R7 R9
        for (int r = 0; r < NV; r++) begin
            wr(0, VEC[r][0]);
            wr(1, VEC[r][1]);
            wr(2, VEC[r][2]);
            repeat (400) @(negedge clk);
            deff = (VEC[r][2] == 0) ? 1 : VEC[r][2];
            per  = 2 * HALF * deff;
            measure(per, h1, h2, ov);
            chk("R4", $sformatf("row %0d pwm_a width", r), h1, exp_on(VEC[r][0]) * deff);
            chk("R4", $sformatf("row %0d pwm_b width", r), h2, exp_on(VEC[r][1]) * deff);
            chk("R6", $sformatf("row %0d overlap", r), ov, 0);
            if (VEC[r][2] == 0)
                chk("R7", "divisor 0 width as divisor 1", h1, exp_on(VEC[r][0]));
            measure(per, g1, g2, gv);
            chk("R9", $sformatf("row %0d repeat a", r), g1, h1);
            chk("R9", $sformatf("row %0d repeat b", r), g2, h2);
            if (exp_on(VEC[r][0]) > 0) begin
                wait_rise(1'b0, t0, ok);
                chk("R3", "rise a found", ok, 1);
                if (exp_on(VEC[r][1]) > 0) begin
                    wait_rise(1'b1, t1, ok);
                    chk("R5", "rise b found", ok, 1);
                    chk("R5", $sformatf("row %0d b offset", r), t1 - t0, HALF * deff);
                end
                wait_rise(1'b0, t2, ok);
                chk("R3", $sformatf("row %0d period", r), t2 - t0, per);
            end
        end

        // R2: read back, spare register has no effect
        wr(0, 64); wr(1, 200); wr(2, 3);
        repeat (400) @(negedge clk);
        wr(3, 8'hA5);
        rd(3, v); chk("R2", "spare readback", v, 8'hA5);
        rd(0, v); chk("R2", "reg 0 readback", v, 64);
        rd(1, v); chk("R2", "reg 1 readback", v, 200);
        rd(2, v); chk("R2", "reg 2 readback", v, 3);
        repeat (300) @(negedge clk);
        measure(2 * HALF * 3, h1, h2, ov);
        chk("R2", "spare no effect a", h1, exp_on(64) * 3);
        chk("R2", "spare no effect b", h2, exp_on(200) * 3);

        // R8: write during a pulse does not cut it
        wr(0, 255); wr(1, 0); wr(2, 1);
        repeat (400) @(negedge clk);
        wait_rise(1'b0, t0, ok);
        chk("R8", "rise a found", ok, 1);
        cnt_hi = 1;
        @(negedge clk);
        cnt_hi += int'(pwm_a);
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'd0;
        @(negedge clk);
        cnt_hi += int'(pwm_a);
        wr_en = 1'b0;
        for (int i = 0; i < 100 && pwm_a; i++) begin
            @(negedge clk);
            cnt_hi += int'(pwm_a);
        end
        chk("R8", "pulse width kept", cnt_hi, CAP);
        measure(2 * HALF * 2, h1, h2, ov);
        chk("R8", "new setting next period", h1, 0);

        // R1: reset in mid-run
        wr(0, 255); wr(1, 255);
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "pwm_a after mid reset", pwm_a, 0);
        chk("R1", "pwm_b after mid reset", pwm_b, 0);
        rd(0, v); chk("R1", "reg 0 after mid reset", v, 0);
        rd(1, v); chk("R1", "reg 1 after mid reset", v, 0);

        finish_run();
    end
endmodule